// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block is the byte-wide register front end of an eight-line programmable interrupt controller. A host reaches it through two byte addresses, selected by a one-bit address, with separate read and write strobes. Writes to address 0 are sorted by their bits 4 and 3 into one of three kinds: the first initialization byte, the end-of-interrupt command byte, or the read-select command byte. Writes to address 1 are steered by an initialization step machine. Outside initialization they load the mask register. During initialization they load, in turn, the vector base, the cascade map and the mode byte.

The block keeps the configuration that the priority core beside it consumes: the mask, the vector base, the cascade map, the auto-EOI flag, edge or level triggering, and cascade or single mode. It turns end-of-interrupt commands into single-cycle pulses toward the core. It also returns the core's request and in-service registers, or its own mask, on reads. Rotation, special mask and buffering commands are accepted and do nothing.

The step machine has four named states:
- `ST_IDLE` (step 0): not initializing.
- `ST_WAIT_BASE` (step 1).
- `ST_WAIT_CASC` (step 2).
- `ST_WAIT_MODE` (step 3).

Its transitions are as follows:
- `T_START`: any state goes to `ST_WAIT_BASE` on an initialization byte.
- `T_BASE_SINGLE`: `ST_WAIT_BASE` goes to `ST_IDLE` on an address-1 write in single mode.
- `T_BASE_CASC`: `ST_WAIT_BASE` goes to `ST_WAIT_CASC` on an address-1 write in cascade mode.
- `T_CASC_DONE`: `ST_WAIT_CASC` goes to `ST_IDLE` on an address-1 write when no mode byte is expected.
- `T_CASC_MODE`: `ST_WAIT_CASC` goes to `ST_WAIT_MODE` on an address-1 write when a mode byte is expected.
- `T_MODE_DONE`: `ST_WAIT_MODE` goes to `ST_IDLE` on an address-1 write.

Top module: `pic_cmd_seq`

## Requirements
- R1: An address-0 write with bit 4 set is an initialization byte. It enters `ST_WAIT_BASE` from any state and clears the mask. It sets edge_trig_o to bit 3 and cascade_mode_o to the inverse of bit 1. It records bit 0 as "mode byte expected".
- R2: An initialization byte with bit 0 clear clears auto_eoi_o. An initialization byte with bit 0 set leaves auto_eoi_o unchanged.
- R3: An address-0 write with bits 4:3 = 00 and bits 7:5 = 001 gives a non-specific EOI. If any in-service bit is set, eoi_valid_o is high for exactly the cycle after the write, with eoi_specific_o = 0 and eoi_line_o set to the index of the highest set in-service bit. If no in-service bit is set, no pulse appears.
- R4: An address-0 write with bits 4:3 = 00 and bits 7:5 = 011 gives a pulse in the cycle after the write, with eoi_specific_o = 1 and eoi_line_o taken from bits 2:0.
- R5: An address-0 write with bits 4:3 = 00 and any other value of bits 7:5 produces no pulse and changes no configuration output.
- R6: An address-0 write with bits 4:3 = 01 and bit 1 set chooses what address-0 reads return: the request register if bit 0 is 1, the in-service register if bit 0 is 0. With bit 1 clear, the choice is unchanged.
- R7: In `ST_IDLE`, an address-1 write loads all eight bits into the mask.
- R8: In `ST_WAIT_BASE`, an address-1 write sets vec_base_o to the written byte with bits 2:0 forced to zero. In cascade mode it then moves to `ST_WAIT_CASC`. In single mode it clears casc_cfg_o and returns to `ST_IDLE`.
- R9: In `ST_WAIT_CASC`, an address-1 write stores the full byte into casc_cfg_o when is_master_i = 1. When is_master_i = 0 it stores only bits 2:0, with the upper bits zero. It then moves to `ST_WAIT_MODE` if a mode byte is expected, and to `ST_IDLE` otherwise.
- R10: In `ST_WAIT_MODE`, an address-1 write sets auto_eoi_o to bit 1 of the byte and returns to `ST_IDLE`.
- R11: A read loads rdata_o at the clock edge where rd_en_i is sampled high. Address 1 returns the mask. Address 0 returns the register chosen under R6. rdata_o holds its value while rd_en_i is low.
- R12: After reset:
  - the step machine is in `ST_IDLE`;
  - the mask, the vector base, the cascade map, rdata_o and all flags are zero;
  - address-0 reads return the request register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| is_master_i | input | 1 | Static role: 1 for master, 0 for slave |
| addr_i | input | 1 | Register address |
| wdata_i | input | 8 | Write byte |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read byte, registered |
| req_i | input | 8 | Request register from the priority core |
| isr_i | input | 8 | In-service register from the priority core |
| mask_o | output | 8 | Mask register |
| vec_base_o | output | 8 | Vector base, bits 2:0 always zero |
| casc_cfg_o | output | 8 | Slave bitmap (master) or slave identity (slave) |
| auto_eoi_o | output | 1 | Auto end-of-interrupt enabled |
| edge_trig_o | output | 1 | 1 for edge triggering, 0 for level triggering |
| cascade_mode_o | output | 1 | 1 for cascade mode, 0 for single mode |
| eoi_valid_o | output | 1 | End-of-interrupt pulse |
| eoi_specific_o | output | 1 | Pulse is a specific EOI |
| eoi_line_o | output | 3 | Line to be retired |

## Verification
Every configuration register, the step machine and the EOI pulse settle one clock edge after the write that causes them. rdata_o settles one edge after the read strobe. The bench drives a strobe on a falling edge and drops it on the next falling edge, so exactly one rising edge sees it. It samples every result on that second falling edge, which is the single cycle in which an EOI pulse is visible. The bench checks that a pulse lasts only one cycle by sampling again one falling edge later. Each state transition is confirmed at the ports: a mask write followed by a mask read shows whether the machine has returned to `ST_IDLE`.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;
    localparam int NUM_LINES = 8;
    localparam int LINE_W    = $clog2(NUM_LINES);
    localparam int BASE_LSB  = LINE_W;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT_BASE = 2'd1,
        ST_WAIT_CASC = 2'd2,
        ST_WAIT_MODE = 2'd3
    } init_step_e;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_INIT = 2'd1,
        CMD_EOI  = 2'd2,
        CMD_RSEL = 2'd3
    } cmd_kind_e;

    localparam logic [2:0] OP_EOI_NONSPEC = 3'b001;
    localparam logic [2:0] OP_EOI_SPEC    = 3'b011;
endpackage

// File: rtl/pic_cmd_classify.sv
module pic_cmd_classify
    import pic_cmd_pkg::*;
(
    input  logic       wr_en,
    input  logic       addr,
    input  logic [1:0] sel_bits,
    output cmd_kind_e  kind
);
    always_comb begin
        if (!wr_en || addr)
            kind = CMD_NONE;
        else if (sel_bits[1])
            kind = CMD_INIT;
        else if (sel_bits[0])
            kind = CMD_RSEL;
        else
            kind = CMD_EOI;
    end
endmodule

// File: rtl/pic_init_fsm.sv
module pic_init_fsm
    import pic_cmd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 is_master,
    input  cmd_kind_e            kind,
    input  logic                 wr1,
    input  logic [NUM_LINES-1:0] wdata,
    output logic [NUM_LINES-1:0] mask,
    output logic [NUM_LINES-1:0] vec_base,
    output logic [NUM_LINES-1:0] casc_cfg,
    output logic                 auto_eoi,
    output logic                 edge_trig,
    output logic                 cascade_mode
);
    init_step_e state_q, state_d;
    logic       need_mode_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (kind == CMD_INIT) begin
            state_d = ST_WAIT_BASE;
        end else if (wr1) begin
            unique case (state_q)
                ST_IDLE:      state_d = ST_IDLE;
                ST_WAIT_BASE: state_d = cascade_mode ? ST_WAIT_CASC : ST_IDLE;
                ST_WAIT_CASC: state_d = need_mode_q ? ST_WAIT_MODE : ST_IDLE;
                ST_WAIT_MODE: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask         <= '0;
            vec_base     <= '0;
            casc_cfg     <= '0;
            auto_eoi     <= 1'b0;
            edge_trig    <= 1'b0;
            cascade_mode <= 1'b0;
            need_mode_q  <= 1'b0;
        end else if (kind == CMD_INIT) begin
            mask         <= '0;
            edge_trig    <= wdata[3];
            cascade_mode <= ~wdata[1];
            need_mode_q  <= wdata[0];
            if (!wdata[0]) auto_eoi <= 1'b0;
        end else if (wr1) begin
            unique case (state_q)
                ST_IDLE: mask <= wdata;
                ST_WAIT_BASE: begin
                    vec_base <= {wdata[NUM_LINES-1:BASE_LSB], {BASE_LSB{1'b0}}};
                    if (!cascade_mode) casc_cfg <= '0;
                end
                ST_WAIT_CASC:
                    casc_cfg <= is_master ? wdata
                                          : {{(NUM_LINES-LINE_W){1'b0}}, wdata[LINE_W-1:0]};
                ST_WAIT_MODE: auto_eoi <= wdata[1];
            endcase
        end
    end

    AST_CASC_AFTER_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_CASC) |-> ($past(state_q) == ST_WAIT_BASE || $past(state_q) == ST_WAIT_CASC)); // R8
    AST_MODE_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_MODE) |-> need_mode_q); // R9
    AST_INIT_CLEARS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == CMD_INIT) |=> (mask == '0 && state_q == ST_WAIT_BASE)); // R1
    AST_SINGLE_NO_CASC: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_BASE && wr1 && !cascade_mode) |=> (casc_cfg == '0 && state_q == ST_IDLE)); // R8
endmodule

// File: rtl/pic_eoi_gen.sv
module pic_eoi_gen
    import pic_cmd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_wr,
    input  logic [2:0]           op_code,
    input  logic [LINE_W-1:0]    op_line,
    input  logic [NUM_LINES-1:0] isr,
    output logic                 eoi_valid,
    output logic                 eoi_specific,
    output logic [LINE_W-1:0]    eoi_line
);
    logic              top_found;
    logic [LINE_W-1:0] top_idx;

    always_comb begin
        top_found = 1'b0;
        top_idx   = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (isr[i]) begin
                top_found = 1'b1;
                top_idx   = LINE_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoi_valid    <= 1'b0;
            eoi_specific <= 1'b0;
            eoi_line     <= '0;
        end else begin
            eoi_valid <= 1'b0;
            if (op_wr && op_code == OP_EOI_SPEC) begin
                eoi_valid    <= 1'b1;
                eoi_specific <= 1'b1;
                eoi_line     <= op_line;
            end else if (op_wr && op_code == OP_EOI_NONSPEC && top_found) begin
                eoi_valid    <= 1'b1;
                eoi_specific <= 1'b0;
                eoi_line     <= top_idx;
            end
        end
    end

    AST_EOI_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid |-> $past(op_wr)); // R5
    AST_NS_EOI_TOP_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && !eoi_specific) |-> (($past(isr) >> eoi_line) == NUM_LINES'(1))); // R3
endmodule

// File: rtl/pic_cmd_seq.sv
module pic_cmd_seq
    import pic_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       is_master_i,
    input  logic       addr_i,
    input  logic [7:0] wdata_i,
    input  logic       wr_en_i,
    input  logic       rd_en_i,
    output logic [7:0] rdata_o,
    input  logic [7:0] req_i,
    input  logic [7:0] isr_i,
    output logic [7:0] mask_o,
    output logic [7:0] vec_base_o,
    output logic [7:0] casc_cfg_o,
    output logic       auto_eoi_o,
    output logic       edge_trig_o,
    output logic       cascade_mode_o,
    output logic       eoi_valid_o,
    output logic       eoi_specific_o,
    output logic [2:0] eoi_line_o
);
    cmd_kind_e kind;
    logic      rd_req_q;

    pic_cmd_classify u_classify (
        .wr_en    (wr_en_i),
        .addr     (addr_i),
        .sel_bits (wdata_i[4:3]),
        .kind     (kind)
    );

    pic_init_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .is_master    (is_master_i),
        .kind         (kind),
        .wr1          (wr_en_i && addr_i),
        .wdata        (wdata_i),
        .mask         (mask_o),
        .vec_base     (vec_base_o),
        .casc_cfg     (casc_cfg_o),
        .auto_eoi     (auto_eoi_o),
        .edge_trig    (edge_trig_o),
        .cascade_mode (cascade_mode_o)
    );

    pic_eoi_gen u_eoi (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_wr        (kind == CMD_EOI),
        .op_code      (wdata_i[7:5]),
        .op_line      (wdata_i[2:0]),
        .isr          (isr_i),
        .eoi_valid    (eoi_valid_o),
        .eoi_specific (eoi_specific_o),
        .eoi_line     (eoi_line_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_req_q <= 1'b1;
            rdata_o  <= '0;
        end else begin
            if (kind == CMD_RSEL && wdata_i[1]) rd_req_q <= wdata_i[0];
            if (rd_en_i) rdata_o <= addr_i ? mask_o : (rd_req_q ? req_i : isr_i);
        end
    end

    AST_READ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i) |=> (rdata_o == $past(mask_o))); // R11
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rdata_o)); // R11
endmodule

// File: tb/test_pic_cmd_seq.sv
module test_pic_cmd_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       is_master = 1'b1;
    logic       addr = 1'b0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rdata, req, isr;
    logic [7:0] mask, vbase, casc;
    logic       aeoi, edge_t, casc_m, ev, es;
    logic [2:0] el;
    int n_chk = 0;
    int n_bad = 0;
    logic       cap_v, cap_s;
    logic [2:0] cap_l;

    always #5 clk = ~clk;

    pic_cmd_seq i_pic_cmd_seq (
        .clk(clk), .rst_n(rst_n), .is_master_i(is_master), .addr_i(addr),
        .wdata_i(wdata), .wr_en_i(wr_en), .rd_en_i(rd_en), .rdata_o(rdata),
        .req_i(req), .isr_i(isr), .mask_o(mask), .vec_base_o(vbase),
        .casc_cfg_o(casc), .auto_eoi_o(aeoi), .edge_trig_o(edge_t),
        .cascade_mode_o(casc_m), .eoi_valid_o(ev), .eoi_specific_o(es),
        .eoi_line_o(el)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        cap_v = ev; cap_s = es; cap_l = el;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    function automatic int top_bit(input logic [7:0] v);
        int r = 0;
        for (int i = 0; i < 8; i++) if (v[i]) r = i;
        return r;
    endfunction

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        req = 8'h96; isr = 8'h41;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset values
        chk("R12 mask", mask, 0); chk("R12 base", vbase, 0); chk("R12 casc", casc, 0);
        chk("R12 aeoi", aeoi, 0); chk("R12 edge", edge_t, 0); chk("R12 rdata", rdata, 0);
        rd(1'b0, v); chk("R12 read selects request", v, 8'h96);
        // R7 idle mask load
        wr(1'b1, 8'h5A); chk("R7 mask", mask, 8'h5A);
        rd(1'b1, v); chk("R11 mask read", v, 8'h5A);
        // R11 hold while rd_en low
        req = 8'h11; @(negedge clk); chk("R11 hold", rdata, 8'h5A);
        // R6 read select
        wr(1'b0, 8'h0A); rd(1'b0, v); chk("R6 select isr", v, 8'h41);
        wr(1'b0, 8'h09); rd(1'b0, v); chk("R6 bit1 clear no change", v, 8'h41);
        wr(1'b0, 8'h0B); rd(1'b0, v); chk("R6 select request", v, 8'h11);

        // R1 R2 R8 R9 R10 sweep over init flags and role
        for (int m = 0; m < 2; m++) begin
            for (int f = 0; f < 8; f++) begin
                logic [7:0] bb;
                logic cm, n4;
                is_master = m[0];
                // preset: auto-EOI on, cascade map non-zero
                wr(1'b0, 8'h11); wr(1'b1, 8'h00); wr(1'b1, 8'hFF); wr(1'b1, 8'h02);
                chk("R10 auto set", aeoi, 1);
                chk("R9 preset casc", casc, m ? 8'hFF : 8'h07);
                wr(1'b1, 8'hA5);
                cm = ~f[1]; n4 = f[0];
                wr(1'b0, 8'h10 | (f[2] << 3) | (f[1] << 1) | f[0]);
                chk("R1 mask cleared", mask, 0);
                chk("R1 edge", edge_t, f[2]);
                chk("R1 cascade", casc_m, cm);
                chk("R2 auto after init", aeoi, n4 ? 1 : 0);
                bb = 8'h07 | 8'(f << 5) | 8'(m << 4);
                wr(1'b1, bb);
                chk("R8 base", vbase, bb & 8'hF8);
                chk("R7 mask untouched in init", mask, 0);
                if (!cm) begin
                    chk("R8 single clears casc", casc, 0);
                end else begin
                    wr(1'b1, 8'hDE);
                    chk("R9 casc store", casc, m ? 8'hDE : 8'h06);
                    if (n4) begin
                        wr(1'b1, f[2] ? 8'h02 : 8'hFD);
                        chk("R10 auto from mode byte", aeoi, f[2]);
                    end
                end
                wr(1'b1, 8'h3C);
                rd(1'b1, v);
                chk("R8 R9 R10 back to idle", v, 8'h3C);
            end
        end

        // R3 R4 R5 command byte sweep
        for (int code = 0; code < 8; code++) begin
            for (int p = 0; p < 5; p++) begin
                logic [7:0] pat;
                logic [7:0] m0, b0, c0;
                logic a0;
                pat = (p == 0) ? 8'h00 : (p == 1) ? 8'h01 : (p == 2) ? 8'h24 : (p == 3) ? 8'h80 : 8'h5A;
                isr = pat;
                m0 = mask; b0 = vbase; c0 = casc; a0 = aeoi;
                wr(1'b0, 8'(code << 5) | 8'h05);
                if (code == 3) begin
                    chk("R4 valid", cap_v, 1); chk("R4 specific", cap_s, 1); chk("R4 line", cap_l, 5);
                end else if (code == 1) begin
                    chk("R3 valid", cap_v, pat != 0);
                    if (pat != 0) begin
                        chk("R3 nonspecific", cap_s, 0); chk("R3 line", cap_l, top_bit(pat));
                    end
                end else begin
                    chk("R5 no pulse", cap_v, 0);
                    chk("R5 mask", mask, m0); chk("R5 base", vbase, b0);
                    chk("R5 casc", casc, c0); chk("R5 auto", aeoi, a0);
                end
                @(negedge clk);
                chk("R3 R4 pulse one cycle", ev, 0);
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule